// File: doc/BRIEF.md
# Address-Triggered Load/Store Register Core

This block is one slice of a register-to-register processor core. It holds three register banks: eight 60-bit data registers, eight 18-bit address registers and eight 18-bit index registers. Its instructions do only two kinds of work. They run three-operand arithmetic and logic on data registers or index registers, or they set an address or index register to a register value plus an 18-bit displacement. No instruction names memory directly.

Memory traffic is a side effect of setting an address register. Setting address register n for n from 1 to 5 reads memory at the new address into data register n. Setting address register 6 or 7 writes data register 6 or 7 to the new address. Setting address register 0 is pure address arithmetic. The memory port is synchronous and returns read data one cycle after the request. While a load is still in flight, the instruction input holds off any instruction that touches the target data register.

Instruction layout (30 bits): opcode in [29:24], i in [23:21], j in [20:18], k in [17:15] for the short form, and an 18-bit displacement in [17:0] for the long form. The debug read port selects a bank with 0 = data, 1 = address, 2 = index and 3 = none.

Top module: `areg_ldst_core`

## Requirements
- R1: After reset every register in all three banks reads zero, `mem_req` is low and `in_ready` is high.
- R2: Short-form data operations write Xi = Xj op Xk modulo 2^60. The opcodes are 0x01 add, 0x02 subtract (Xj minus Xk), 0x03 AND, 0x04 OR and 0x05 XOR.
- R3: Index operations 0x08 (Bi = Bj + Bk) and 0x09 (Bi = Bj - Bk) wrap modulo 2^18. Index register 0 always reads zero, and writes to it have no effect.
- R4: Long-form opcodes wrap modulo 2^18: 0x10 sets Ai = Aj + disp, 0x11 sets Ai = Bj + disp and 0x12 sets Bi = Bj + disp.
- R5: Setting Ai for i in 1..5 drives a read request (`mem_req`=1, `mem_we`=0, `mem_addr` = new Ai) in the cycle after acceptance. The data returned one cycle later is written into Xi at the end of that cycle.
- R6: Setting Ai for i in 6..7 drives a write request in the cycle after acceptance, with `mem_addr` = new Ai and `mem_wdata` = Xi as it was when the instruction was accepted.
- R7: Setting A0 updates A0 and never raises `mem_req`.
- R8: `in_ready` falls only when the presented instruction reads or writes a data register that has a load in flight. An instruction that reads a data register presented right after its load waits exactly two cycles, and an unrelated instruction waits none.
- R9: The debug port returns the selected register combinationally, zero-extended for 18-bit banks. Bank selector 3 returns zero.
- R10: An opcode outside the listed set changes no register and raises no memory request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction accepted this cycle when high with in_valid |
| in_instr | input | 30 | Instruction word |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 18 | Memory word address |
| mem_wdata | output | 60 | Store data |
| mem_rdata | input | 60 | Read data, valid the cycle after a read request |
| dbg_bank | input | 2 | Debug bank select |
| dbg_idx | input | 3 | Debug register index |
| dbg_data | output | 60 | Debug read value |

## Verification
A wrong pending-load state shows up at `in_ready` within the cycle the dependent instruction is presented: either a spurious stall, or an acceptance that later reads the stale data register through the debug port. A wrong address register shows up at `mem_addr` in the cycle right after the setting instruction, and a wrong loaded value is visible on the debug port two cycles after acceptance. Arithmetic faults in the data or index units appear on the debug port one cycle after the operation is accepted. Register-zero handling shows up as a nonzero index 0 or a stray `mem_req`.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [5:0] {
    OP_NOP   = 6'h00,
    OP_XADD  = 6'h01,
    OP_XSUB  = 6'h02,
    OP_XAND  = 6'h03,
    OP_XIOR  = 6'h04,
    OP_XXOR  = 6'h05,
    OP_BADD  = 6'h08,
    OP_BSUB  = 6'h09,
    OP_ASETA = 6'h10,
    OP_ASETB = 6'h11,
    OP_BSET  = 6'h12
  } op_e;

  typedef enum logic [1:0] {
    BANK_X    = 2'd0,
    BANK_A    = 2'd1,
    BANK_B    = 2'd2,
    BANK_NONE = 2'd3
  } bank_e;
endpackage

// File: rtl/ldst_regbank.sv
module ldst_regbank #(
  parameter int W     = 18,
  parameter int N     = 8,
  parameter bit ZERO0 = 1'b0,
  localparam int IW   = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we0,
  input  logic [IW-1:0] wa0,
  input  logic [W-1:0]  wd0,
  input  logic          we1,
  input  logic [IW-1:0] wa1,
  input  logic [W-1:0]  wd1,
  output logic [W-1:0]  q [N]
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < N; r++) regs[r] <= '0;
    end else begin
      for (int r = 0; r < N; r++) begin
        if (we1 && wa1 == IW'(r))      regs[r] <= wd1;
        else if (we0 && wa0 == IW'(r)) regs[r] <= wd0;
      end
    end
  end

  always_comb begin
    for (int r = 0; r < N; r++) q[r] = regs[r];
    if (ZERO0) q[0] = '0;
  end

  // R5
  port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we0 && we1) |-> (wa0 != wa1));
endmodule

// File: rtl/ldst_memctl.sv
module ldst_memctl #(
  parameter int DW       = 60,
  parameter int AW       = 18,
  parameter int N        = 8,
  parameter int LD_FIRST = 1,
  parameter int LD_LAST  = 5,
  parameter int ST_FIRST = 6,
  localparam int IW      = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_fire,
  input  logic [IW-1:0] a_idx,
  input  logic [AW-1:0] a_new,
  input  logic [DW-1:0] st_data,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          wb_en,
  output logic [IW-1:0] wb_idx,
  output logic [DW-1:0] wb_data,
  output logic [N-1:0]  pend
);
  logic          is_ld, is_st;
  logic          s1_v, s2_v;
  logic [IW-1:0] s1_idx, s2_idx;

  assign is_ld = a_fire && int'(a_idx) >= LD_FIRST && int'(a_idx) <= LD_LAST;
  assign is_st = a_fire && int'(a_idx) >= ST_FIRST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      s1_v      <= 1'b0;
      s2_v      <= 1'b0;
      s1_idx    <= '0;
      s2_idx    <= '0;
    end else begin
      mem_req <= is_ld || is_st;
      mem_we  <= is_st;
      if (is_ld || is_st) mem_addr <= a_new;
      if (is_st) mem_wdata <= st_data;
      s1_v   <= is_ld;
      s1_idx <= a_idx;
      s2_v   <= s1_v;
      s2_idx <= s1_idx;
    end
  end

  assign wb_en   = s2_v;
  assign wb_idx  = s2_idx;
  assign wb_data = mem_rdata;

  always_comb begin
    pend = '0;
    if (s1_v) pend[s1_idx] = 1'b1;
    if (s2_v) pend[s2_idx] = 1'b1;
  end

  // R7
  a0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_fire && a_idx == '0) |=> !mem_req);

  // R5
  load_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> wb_en);

  // R6
  store_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_fire && int'(a_idx) >= ST_FIRST) |=>
      (mem_req && mem_we && mem_wdata == $past(st_data)));
endmodule

// File: rtl/areg_ldst_core.sv
module areg_ldst_core #(
  parameter int DW    = 60,
  parameter int AW    = 18,
  parameter int NREG  = 8,
  localparam int OPW  = $bits(ldst_pkg::op_e),
  localparam int RIW  = $clog2(NREG),
  localparam int IRW  = OPW + 2 * RIW + AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [IRW-1:0] in_instr,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic [1:0]     dbg_bank,
  input  logic [RIW-1:0] dbg_idx,
  output logic [DW-1:0]  dbg_data
);
  import ldst_pkg::*;

  function automatic logic [DW-1:0] x_alu(input logic [OPW-1:0] f,
                                          input logic [DW-1:0] a, b);
    case (f)
      OP_XADD: return a + b;
      OP_XSUB: return a - b;
      OP_XAND: return a & b;
      OP_XIOR: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic [AW-1:0] addr_sum(input logic [AW-1:0] a, b);
    return a + b;
  endfunction

  function automatic logic [NREG-1:0] sel_bit(input logic [RIW-1:0] r);
    logic [NREG-1:0] m;
    m = '0;
    m[r] = 1'b1;
    return m;
  endfunction

  logic [OPW-1:0]  op;
  logic [RIW-1:0]  fi, fj, fk;
  logic [AW-1:0]   disp;
  assign op   = in_instr[IRW-1 -: OPW];
  assign fi   = in_instr[IRW-OPW-1 -: RIW];
  assign fj   = in_instr[IRW-OPW-RIW-1 -: RIW];
  assign fk   = in_instr[AW-1 -: RIW];
  assign disp = in_instr[AW-1:0];

  logic [DW-1:0] xq [NREG];
  logic [AW-1:0] aq [NREG];
  logic [AW-1:0] bq [NREG];

  logic            x_op, a_op, b_op, op_known;
  logic [DW-1:0]   x_res;
  logic [AW-1:0]   a_res, b_res;
  logic [NREG-1:0] need, pend;
  logic            fire, hazard;

  always_comb begin
    x_op = 1'b0; a_op = 1'b0; b_op = 1'b0;
    op_known = (op == OP_NOP);
    need  = '0;
    x_res = x_alu(op, xq[fj], xq[fk]);
    a_res = addr_sum(aq[fj], disp);
    b_res = addr_sum(bq[fj], bq[fk]);
    case (op)
      OP_XADD, OP_XSUB, OP_XAND, OP_XIOR, OP_XXOR: begin
        x_op = 1'b1; op_known = 1'b1;
        need = sel_bit(fi) | sel_bit(fj) | sel_bit(fk);
      end
      OP_BADD: begin b_op = 1'b1; op_known = 1'b1; end
      OP_BSUB: begin
        b_op = 1'b1; op_known = 1'b1;
        b_res = bq[fj] - bq[fk];
      end
      OP_ASETA: begin a_op = 1'b1; op_known = 1'b1; need = sel_bit(fi); end
      OP_ASETB: begin
        a_op = 1'b1; op_known = 1'b1; need = sel_bit(fi);
        a_res = addr_sum(bq[fj], disp);
      end
      OP_BSET: begin
        b_op = 1'b1; op_known = 1'b1;
        b_res = addr_sum(bq[fj], disp);
      end
      default: ;
    endcase
  end

  assign hazard   = |(need & pend);
  assign in_ready = !hazard;
  assign fire     = in_valid && in_ready;

  logic            wb_en;
  logic [RIW-1:0]  wb_idx;
  logic [DW-1:0]   wb_data;

  ldst_memctl #(.DW(DW), .AW(AW), .N(NREG)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .a_fire(fire && a_op), .a_idx(fi), .a_new(a_res), .st_data(xq[fi]),
    .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .pend(pend)
  );

  ldst_regbank #(.W(DW), .N(NREG), .ZERO0(1'b0)) u_xbank (
    .clk(clk), .rst_n(rst_n),
    .we0(fire && x_op), .wa0(fi), .wd0(x_res),
    .we1(wb_en), .wa1(wb_idx), .wd1(wb_data), .q(xq)
  );

  ldst_regbank #(.W(AW), .N(NREG), .ZERO0(1'b0)) u_abank (
    .clk(clk), .rst_n(rst_n),
    .we0(fire && a_op), .wa0(fi), .wd0(a_res),
    .we1(1'b0), .wa1('0), .wd1('0), .q(aq)
  );

  ldst_regbank #(.W(AW), .N(NREG), .ZERO0(1'b1)) u_bbank (
    .clk(clk), .rst_n(rst_n),
    .we0(fire && b_op), .wa0(fi), .wd0(b_res),
    .we1(1'b0), .wa1('0), .wd1('0), .q(bq)
  );

  always_comb begin
    case (bank_e'(dbg_bank))
      BANK_X:  dbg_data = xq[dbg_idx];
      BANK_A:  dbg_data = {{(DW-AW){1'b0}}, aq[dbg_idx]};
      BANK_B:  dbg_data = {{(DW-AW){1'b0}}, bq[dbg_idx]};
      default: dbg_data = '0;
    endcase
  end

  // R8
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (pend != '0));

  // R10
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !op_known) |=> !mem_req);
endmodule

// File: tb/sim_areg_ldst_core.sv
`timescale 1ns/100ps
module sim_areg_ldst_core;
  localparam int DW = 60;
  localparam int AW = 18;
  localparam logic [5:0] C_XADD = 6'h01, C_XSUB = 6'h02, C_XAND = 6'h03,
                         C_XIOR = 6'h04, C_XXOR = 6'h05, C_BADD = 6'h08,
                         C_BSUB = 6'h09, C_ASETA = 6'h10, C_ASETB = 6'h11,
                         C_BSET = 6'h12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [29:0]   in_instr = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [1:0]    dbg_bank = 2'd0;
  logic [2:0]    dbg_idx = 3'd0;
  logic [DW-1:0] dbg_data;

  areg_ldst_core u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dbg_bank(dbg_bank), .dbg_idx(dbg_idx), .dbg_data(dbg_data)
  );

  logic [DW-1:0] mem [256];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] xm [8];
  logic [AW-1:0] am [8];
  logic [AW-1:0] bm [8];

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] bank, input int idx, output logic [DW-1:0] v);
    @(negedge clk);
    dbg_bank = bank;
    dbg_idx  = 3'(idx);
    #0.1;
    v = dbg_data;
  endtask

  task automatic issue(input logic [29:0] ins, output int waits);
    in_instr = ins;
    in_valid = 1'b1;
    waits = 0;
    #0.5;
    while (!in_ready) begin
      @(negedge clk);
      #0.5;
      waits++;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_instr = '0;
  endtask

  function automatic logic [29:0] mk_s(input logic [5:0] op, input int i, input int j, input int k);
    return {op, 3'(i), 3'(j), 3'(k), 15'd0};
  endfunction

  function automatic logic [29:0] mk_l(input logic [5:0] op, input int i, input int j, input logic [AW-1:0] d);
    return {op, 3'(i), 3'(j), d};
  endfunction

  function automatic logic [DW-1:0] ref_alu(input logic [5:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] t;
    case (op)
      C_XADD: begin t = {1'b0, a} + {1'b0, b}; return t[DW-1:0]; end
      C_XSUB: begin t = {1'b0, a} + {1'b0, ~b} + 1; return t[DW-1:0]; end
      C_XAND: return a & b;
      C_XIOR: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic check_all(input string tag);
    logic [DW-1:0] v;
    for (int r = 0; r < 8; r++) begin
      rd(2'd0, r, v); check({tag, " X"}, v, xm[r]);
      rd(2'd1, r, v); check({tag, " A"}, v, {{(DW-AW){1'b0}}, am[r]});
      rd(2'd2, r, v); check({tag, " B"}, v, {{(DW-AW){1'b0}}, bm[r]});
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    logic [AW-1:0] ad;
    int w;
    for (int a = 0; a < 256; a++)
      mem[a] = 60'h0F1E2D3C4B5A697 ^ (60'(a) * 60'h1_0000_0001_0003);
    for (int r = 0; r < 8; r++) begin xm[r] = '0; am[r] = '0; bm[r] = '0; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.1;
    // R1 reset state
    check("R1 in_ready", {59'd0, in_ready}, 60'd1);
    check("R1 mem_req", {59'd0, mem_req}, 60'd0);
    check_all("R1 R9 reset");
    rd(2'd3, 5, v); check("R9 bank none", v, '0);

    // R5 loads into X1..X5
    for (int r = 1; r <= 5; r++) begin
      ad = 18'(r * 8 + 3);
      issue(mk_l(C_ASETA, r, 0, ad), w);
      check("R5 read req", {57'd0, mem_req, mem_we, 1'b0}, {57'd0, 1'b1, 1'b0, 1'b0});
      check("R5 read addr", {{(DW-AW){1'b0}}, mem_addr}, {{(DW-AW){1'b0}}, ad});
      am[r] = ad;
      xm[r] = mem[ad[7:0]];
    end
    repeat (3) @(negedge clk);
    check_all("R5 R4 after loads");

    // R2 sweep of data ops
    for (int op = 1; op <= 5; op++)
      for (int j = 1; j <= 5; j++)
        for (int k = 1; k <= 5; k++) begin
          int i;
          i = 6 + (k & 1);
          issue(mk_s(6'(op), i, j, k), w);
          xm[i] = ref_alu(6'(op), xm[j], xm[k]);
          rd(2'd0, i, v);
          check("R2 data op", v, xm[i]);
        end
    issue(mk_s(C_XADD, 6, 6, 6), w);
    xm[6] = ref_alu(C_XADD, xm[6], xm[6]);
    rd(2'd0, 6, v); check("R2 in place", v, xm[6]);

    // R4 index set with displacement, R3 zero index
    for (int r = 0; r < 8; r++) begin
      issue(mk_l(C_BSET, r, 0, 18'h3FFF0 + 18'(r)), w);
      if (r != 0) bm[r] = 18'h3FFF0 + 18'(r);
    end
    check_all("R4 R3 index set");
    // R3 index add/sub sweep
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 8; k++) begin
        int i;
        logic [5:0] op;
        i  = (j * 3 + k) % 8;
        op = ((j + k) % 2 == 0) ? C_BADD : C_BSUB;
        issue(mk_s(op, i, j, k), w);
        if (i != 0) bm[i] = (op == C_BADD) ? bm[j] + bm[k] : bm[j] + (~bm[k]) + 18'd1;
        rd(2'd2, i, v);
        check("R3 index op", v, {{(DW-AW){1'b0}}, bm[i]});
      end

    // R7 A0 update and R4 wrap from index
    issue(mk_l(C_ASETB, 0, 3, 18'h3FFFF), w);
    check("R7 no req", {59'd0, mem_req}, 60'd0);
    am[0] = bm[3] + 18'h3FFFF;
    rd(2'd1, 0, v); check("R4 R7 A0", v, {{(DW-AW){1'b0}}, am[0]});
    issue(mk_l(C_ASETA, 0, 0, 18'h2_0001), w);
    check("R7 no req again", {59'd0, mem_req}, 60'd0);
    am[0] = am[0] + 18'h2_0001;
    rd(2'd1, 0, v); check("R4 A0 self wrap", v, {{(DW-AW){1'b0}}, am[0]});

    // R6 store then reload
    issue(mk_s(C_XXOR, 6, 1, 2), w);
    xm[6] = xm[1] ^ xm[2];
    ad = 18'd200 - am[0];
    issue(mk_l(C_ASETA, 6, 0, ad), w);
    am[6] = am[0] + ad;
    check("R6 write req", {58'd0, mem_req, mem_we}, {58'd0, 1'b1, 1'b1});
    check("R6 write addr", {{(DW-AW){1'b0}}, mem_addr}, {{(DW-AW){1'b0}}, am[6]});
    check("R6 write data", mem_wdata, xm[6]);
    @(negedge clk);
    issue(mk_l(C_ASETA, 3, 0, ad), w);
    am[3] = am[6];
    xm[3] = xm[6];
    repeat (3) @(negedge clk);
    rd(2'd0, 3, v); check("R6 round trip", v, xm[3]);
    issue(mk_l(C_ASETB, 7, 0, 18'd77), w);
    am[7] = 18'd77;
    check("R6 store X7 data", mem_wdata, xm[7]);
    check("R6 store X7 addr", {{(DW-AW){1'b0}}, mem_addr}, 60'd77);

    // R8 dependent instruction stalls two cycles
    ad = 18'd90 - am[0];
    issue(mk_l(C_ASETA, 2, 0, ad), w);
    am[2] = am[0] + ad;
    xm[2] = mem[am[2][7:0]];
    issue(mk_s(C_XADD, 6, 2, 3), w);
    check("R8 dependent waits", 60'(w), 60'd2);
    xm[6] = ref_alu(C_XADD, xm[2], xm[3]);
    rd(2'd0, 6, v); check("R8 fresh operand", v, xm[6]);
    // R8 unrelated instruction does not stall
    ad = 18'd91 - am[0];
    issue(mk_l(C_ASETA, 4, 0, ad), w);
    am[4] = am[0] + ad;
    xm[4] = mem[am[4][7:0]];
    issue(mk_s(C_XIOR, 7, 1, 5), w);
    check("R8 unrelated waits", 60'(w), 60'd0);
    xm[7] = xm[1] | xm[5];
    // R8 back-to-back loads to one register
    ad = 18'd92 - am[0];
    issue(mk_l(C_ASETA, 1, 0, ad), w);
    ad = 18'd93 - am[0];
    issue(mk_l(C_ASETA, 1, 0, ad), w);
    check("R8 same target waits", 60'(w), 60'd2);
    am[1] = am[0] + ad;
    xm[1] = mem[am[1][7:0]];
    repeat (3) @(negedge clk);
    check_all("R8 after stalls");

    // R10 unknown opcode
    issue({6'h3F, 3'd1, 3'd2, 18'h1234}, w);
    check("R10 no req", {59'd0, mem_req}, 60'd0);
    issue({6'h16, 3'd6, 3'd0, 18'h0042}, w);
    check("R10 no req 2", {59'd0, mem_req}, 60'd0);
    check_all("R10 unchanged");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule